// File: doc/BRIEF.md
# Flash Erase/Program Control Register Unit

This unit is a small set of special-function registers on an 8-bit microcontroller register bus. Firmware uses it to steer an on-chip flash array. It holds the number of the page to erase. It turns specific command bytes into single-cycle erase requests for the flash controller. It also holds a control byte with four bits:

- a program-space write select that routes external-data stores into flash;
- a mass-erase enable;
- a set-only security flag;
- a read-only preboot indication.

The unit is guarded against stray commands. A page erase is honoured only when the page register has been written since the previous page erase. A mass erase is honoured only when the mass-erase enable is set and the debug port is enabled. Each accepted erase uses up its own arming. The program-space write select clears itself after every flash byte, and it cannot be changed while interrupts are globally enabled.

There is no data stream through this block. All pins are plain control and status levels or strobes. The erase requests are fire-and-forget pulses: there is no ready signal, and back-pressure is expressed only through the `flash_busy` level. While `flash_busy` is high, an erase command is dropped.

Top module: `flash_ctl_sfr`

## Requirements
- R1: After reset, both erase requests, `prog_sel`, `secure` and `erase_page` are 0, and every register reads 0 except the preboot bit.
- R2: A write of 0x55 to address 0x94, with the page register armed and `flash_busy` low, raises `page_erase_req` for exactly the one cycle after the write. During that cycle `erase_page` carries the latched page number.
- R3: Writing the page register (address 0xB7) arms it, and an accepted page erase disarms it. A second 0x55 without a new page write gives no request.
- R4: A write of 0xAA to address 0x94 raises `mass_erase_req` for the one cycle after the write, only if the mass-erase enable (control bit 1) is set and `dbg_en` is high.
- R5: The mass-erase enable clears when a mass erase is accepted. A refused 0xAA leaves it set.
- R6: Any byte other than 0x55 or 0xAA written to address 0x94 has no effect: no request is raised and no arming is changed.
- R7: An erase command written while `flash_busy` is high is dropped and leaves both armings unchanged.
- R8: Control bit 0 drives `prog_sel`. A write to it takes effect only while `irq_en` is low.
- R9: A `byte_done` strobe clears `prog_sel` on the next edge. It wins over a simultaneous write of 1.
- R10: `secure` (control bit 6) is set by writing 1. Writing 0 leaves it set, and only reset clears it.
- R11: Reads are combinational and gated by `sfr_rd`, returning 0 when `sfr_rd` is low or the address is unknown. The control register (0xB2) reads preboot in bit 7, secure in bit 6, 0 in bits 5..2, enable in bit 1 and `prog_sel` in bit 0, and writes to bits 7..2 other than bit 6 are ignored. The page register reads its 7-bit value with bit 7 at 0, and bit 7 of a write is ignored. The command register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_wr | input | 1 | Register write strobe |
| sfr_rd | input | 1 | Register read strobe |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data, combinational |
| irq_en | input | 1 | Global interrupt enable level |
| dbg_en | input | 1 | Debug port enabled level |
| preboot_in | input | 1 | Preboot sequence active |
| flash_busy | input | 1 | Flash array busy |
| byte_done | input | 1 | One flash byte write completed |
| page_erase_req | output | 1 | One-cycle page-erase request |
| mass_erase_req | output | 1 | One-cycle mass-erase request |
| erase_page | output | 7 | Latched page number |
| prog_sel | output | 1 | External-data stores go to program flash |
| secure | output | 1 | Security flag |

## Verification
Erase requests are due exactly one cycle after the write edge that carries the command. Register effects such as `prog_sel`, `secure`, the armings and the read-back values settle at that same edge, while `sfr_rdata` follows the address combinationally. The bench drives inputs and samples outputs on falling edges. Each write queues its expected request with the cycle number at which it is due, and a monitor compares the request pins on every falling edge against the queue head, so early, late, missing and extra pulses all fail. Register state is read back one falling edge after the write that changed it, a nanosecond after `sfr_rd` is raised.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int SFR_DW = 8;
  localparam logic [SFR_DW-1:0] ADR_ERASE = 8'h94;
  localparam logic [SFR_DW-1:0] ADR_PAGE  = 8'hB7;
  localparam logic [SFR_DW-1:0] ADR_CTRL  = 8'hB2;
  localparam logic [SFR_DW-1:0] CMD_PAGE  = 8'h55;
  localparam logic [SFR_DW-1:0] CMD_MASS  = 8'hAA;
  localparam int BIT_PWE  = 0;
  localparam int BIT_MEEN = 1;
  localparam int BIT_SEC  = 6;
  localparam int BIT_PRE  = 7;
  typedef enum logic [1:0] {REQ_NONE, REQ_PAGE, REQ_MASS} erase_req_e;
endpackage

// File: rtl/fcs_page_reg.sv
module fcs_page_reg #(
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wdata,
  input  logic              consume,
  output logic [PAGE_W-1:0] page_q,
  output logic              armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      armed  <= 1'b0;
    end else begin
      if (wr_en) begin
        page_q <= wdata;
        armed  <= 1'b1;
      end else if (consume) begin
        armed  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fcs_ctrl_reg.sv
module fcs_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic pwe_d,
  input  logic meen_d,
  input  logic sec_d,
  input  logic irq_en,
  input  logic byte_done,
  input  logic mass_start,
  output logic pwe,
  output logic meen,
  output logic secure
);
  // program write enable: self-clearing, frozen while interrupts are on
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pwe <= 1'b0;
    else if (byte_done)        pwe <= 1'b0;
    else if (wr_en && !irq_en) pwe <= pwe_d;
  end

  // mass-erase enable: used up by an accepted mass erase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          meen <= 1'b0;
    else if (wr_en)      meen <= meen_d;
    else if (mass_start) meen <= 1'b0;
  end

  // security flag: set-only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              secure <= 1'b0;
    else if (wr_en && sec_d) secure <= 1'b1;
  end
endmodule

// File: rtl/fcs_erase_dec.sv
module fcs_erase_dec
  import fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SFR_DW-1:0] wdata,
  input  logic              busy,
  input  logic              page_armed,
  input  logic              meen,
  input  logic              dbg_en,
  output logic              page_start,
  output logic              mass_start,
  output logic              page_req,
  output logic              mass_req
);
  erase_req_e req_c;

  always_comb begin
    req_c = REQ_NONE;
    if (wr_en && !busy) begin
      if (wdata == CMD_PAGE && page_armed)
        req_c = REQ_PAGE;
      else if (wdata == CMD_MASS && meen && dbg_en)
        req_c = REQ_MASS;
    end
  end

  assign page_start = (req_c == REQ_PAGE);
  assign mass_start = (req_c == REQ_MASS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_req <= 1'b0;
      mass_req <= 1'b0;
    end else begin
      page_req <= page_start;
      mass_req <= mass_start;
    end
  end
endmodule

// File: rtl/flash_ctl_sfr.sv
module flash_ctl_sfr
  import fcs_pkg::*;
#(
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_wr,
  input  logic              sfr_rd,
  input  logic [SFR_DW-1:0] sfr_addr,
  input  logic [SFR_DW-1:0] sfr_wdata,
  output logic [SFR_DW-1:0] sfr_rdata,
  input  logic              irq_en,
  input  logic              dbg_en,
  input  logic              preboot_in,
  input  logic              flash_busy,
  input  logic              byte_done,
  output logic              page_erase_req,
  output logic              mass_erase_req,
  output logic [PAGE_W-1:0] erase_page,
  output logic              prog_sel,
  output logic              secure
);
  logic wr_erase, wr_page, wr_ctrl;
  logic page_armed, page_start, mass_start;
  logic ctl_pwe, ctl_meen;
  logic [PAGE_W-1:0] page_q;
  logic [SFR_DW-1:0] ctrl_view, rd_mux;

  assign wr_erase = sfr_wr && (sfr_addr == ADR_ERASE);
  assign wr_page  = sfr_wr && (sfr_addr == ADR_PAGE);
  assign wr_ctrl  = sfr_wr && (sfr_addr == ADR_CTRL);

  fcs_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_page),
    .wdata(sfr_wdata[PAGE_W-1:0]), .consume(page_start),
    .page_q(page_q), .armed(page_armed)
  );

  fcs_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl),
    .pwe_d(sfr_wdata[BIT_PWE]), .meen_d(sfr_wdata[BIT_MEEN]),
    .sec_d(sfr_wdata[BIT_SEC]), .irq_en(irq_en), .byte_done(byte_done),
    .mass_start(mass_start), .pwe(ctl_pwe), .meen(ctl_meen), .secure(secure)
  );

  fcs_erase_dec u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_erase), .wdata(sfr_wdata),
    .busy(flash_busy), .page_armed(page_armed), .meen(ctl_meen),
    .dbg_en(dbg_en), .page_start(page_start), .mass_start(mass_start),
    .page_req(page_erase_req), .mass_req(mass_erase_req)
  );

  always_comb begin
    ctrl_view           = '0;
    ctrl_view[BIT_PWE]  = ctl_pwe;
    ctrl_view[BIT_MEEN] = ctl_meen;
    ctrl_view[BIT_SEC]  = secure;
    ctrl_view[BIT_PRE]  = preboot_in;
  end

  always_comb begin
    case (sfr_addr)
      ADR_CTRL: rd_mux = ctrl_view;
      ADR_PAGE: rd_mux = SFR_DW'(page_q);
      default:  rd_mux = '0;
    endcase
  end

  assign sfr_rdata  = sfr_rd ? rd_mux : '0;
  assign erase_page = page_q;
  assign prog_sel   = ctl_pwe;
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
  import fcs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sfr_wr,
  input logic [SFR_DW-1:0] sfr_addr,
  input logic [SFR_DW-1:0] sfr_wdata,
  input logic              flash_busy,
  input logic              dbg_en,
  input logic              irq_en,
  input logic              byte_done,
  input logic              page_erase_req,
  input logic              mass_erase_req,
  input logic              prog_sel,
  input logic              secure,
  input logic              page_armed,
  input logic              meen
);
  p_req_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({page_erase_req, mass_erase_req}));

  p_page_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    page_erase_req |=> !page_erase_req);

  p_page_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    page_erase_req |-> $past(sfr_wr && sfr_addr == ADR_ERASE &&
                             sfr_wdata == CMD_PAGE && !flash_busy));

  p_page_disarm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    page_erase_req |-> !page_armed);

  p_mass_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mass_erase_req |-> $past(sfr_wr && sfr_addr == ADR_ERASE &&
                             sfr_wdata == CMD_MASS && dbg_en && !flash_busy));

  p_mass_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mass_erase_req |=> !mass_erase_req);

  p_meen_used_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mass_erase_req |-> !meen);

  p_pwe_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && !byte_done) |=> (prog_sel == $past(prog_sel)));

  p_pwe_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !prog_sel);

  p_secure_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    secure |=> secure);
endmodule

bind flash_ctl_sfr fcs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
  .sfr_wdata(sfr_wdata), .flash_busy(flash_busy), .dbg_en(dbg_en),
  .irq_en(irq_en), .byte_done(byte_done), .page_erase_req(page_erase_req),
  .mass_erase_req(mass_erase_req), .prog_sel(prog_sel), .secure(secure),
  .page_armed(page_armed), .meen(ctl_meen)
);

// File: tb/flash_ctl_sfr_bench.sv
module flash_ctl_sfr_bench;
  logic clk = 0, rst_n = 0;
  logic sfr_wr = 0, sfr_rd = 0;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0, sfr_rdata;
  logic irq_en = 0, dbg_en = 0, preboot_in = 0, flash_busy = 0, byte_done = 0;
  logic page_erase_req, mass_erase_req, prog_sel, secure;
  logic [6:0] erase_page;

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0;

  typedef struct { int due; bit mass; int page; } exp_t;
  exp_t q[$];

  flash_ctl_sfr u_flash_ctl_sfr (
    .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .irq_en(irq_en), .dbg_en(dbg_en), .preboot_in(preboot_in),
    .flash_busy(flash_busy), .byte_done(byte_done),
    .page_erase_req(page_erase_req), .mass_erase_req(mass_erase_req),
    .erase_page(erase_page), .prog_sel(prog_sel), .secure(secure)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // kind: 0 no request, 1 page request, 2 mass request
  task automatic sfr_write(logic [7:0] a, logic [7:0] d, int kind = 0, int pg = 0);
    exp_t e;
    @(negedge clk);
    sfr_wr = 1; sfr_addr = a; sfr_wdata = d;
    if (kind != 0) begin
      e.due = cyc + 1; e.mass = (kind == 2); e.page = pg;
      q.push_back(e);
    end
    @(negedge clk);
    sfr_wr = 0;
  endtask

  task automatic sfr_read(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    sfr_rd = 1; sfr_addr = a;
    #1 d = sfr_rdata;
    sfr_rd = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      bit ep, em; int pg;
      ep = 0; em = 0; pg = 0;
      if (q.size() > 0 && q[0].due == cyc) begin
        ep = !q[0].mass; em = q[0].mass; pg = q[0].page;
        void'(q.pop_front());
      end
      if (ep || em || page_erase_req || mass_erase_req) begin
        check("R2 page_erase_req", page_erase_req, ep);
        check("R4 mass_erase_req", mass_erase_req, em);
        if (ep) check("R2 erase_page", erase_page, pg);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 page_erase_req", page_erase_req, 0);
    check("R1 mass_erase_req", mass_erase_req, 0);
    check("R1 prog_sel", prog_sel, 0);
    check("R1 secure", secure, 0);
    check("R1 erase_page", erase_page, 0);
    sfr_read(8'hB2, r); check("R1 ctrl read", r, 8'h00);
    sfr_read(8'hB7, r); check("R1 page read", r, 8'h00);

    // R11 top page bit ignored; R2 page erase
    sfr_write(8'hB7, 8'h85);
    sfr_read(8'hB7, r); check("R11 page read", r, 8'h05);
    sfr_read(8'h94, r); check("R11 erase reg read", r, 8'h00);
    sfr_write(8'h94, 8'h55, 1, 5);
    // R3 disarmed: no request expected
    sfr_write(8'h94, 8'h55);
    repeat (2) @(negedge clk);

    // R6 other codes ignored, arming kept
    sfr_write(8'hB7, 8'h09);
    sfr_write(8'h94, 8'h12);
    sfr_write(8'h94, 8'hAA);
    sfr_write(8'h94, 8'h00);
    sfr_write(8'h94, 8'h55, 1, 9);

    // R7 busy drops command
    sfr_write(8'hB7, 8'h7F);
    flash_busy = 1;
    sfr_write(8'h94, 8'h55);
    flash_busy = 0;
    sfr_write(8'h94, 8'h55, 1, 127);

    // R4 mass erase gating, R5 enable used up
    sfr_write(8'hB2, 8'h02);
    sfr_read(8'hB2, r); check("R4 meen set", r, 8'h02);
    sfr_write(8'h94, 8'hAA);            // dbg_en low: refused
    sfr_read(8'hB2, r); check("R5 meen kept after refusal", r, 8'h02);
    flash_busy = 1; dbg_en = 1;
    sfr_write(8'h94, 8'hAA);            // R7 busy: refused
    flash_busy = 0;
    sfr_read(8'hB2, r); check("R7 meen kept while busy", r, 8'h02);
    sfr_write(8'h94, 8'hAA, 2);
    sfr_read(8'hB2, r); check("R5 meen cleared", r, 8'h00);
    sfr_write(8'h94, 8'hAA);            // no second mass erase
    sfr_write(8'hB2, 8'h00);
    dbg_en = 0;
    sfr_write(8'h94, 8'hAA);            // R4 meen clear: refused

    // R8 write gated by irq_en
    irq_en = 1;
    sfr_write(8'hB2, 8'h01);
    check("R8 blocked by irq_en", prog_sel, 0);
    irq_en = 0;
    sfr_write(8'hB2, 8'h01);
    check("R8 prog_sel set", prog_sel, 1);
    irq_en = 1;
    sfr_write(8'hB2, 8'h00);
    check("R8 clear blocked by irq_en", prog_sel, 1);
    irq_en = 0;
    // R9 byte_done clears
    @(negedge clk); byte_done = 1;
    @(negedge clk); byte_done = 0;
    check("R9 cleared by byte_done", prog_sel, 0);
    sfr_write(8'hB2, 8'h01);
    @(negedge clk);
    sfr_wr = 1; sfr_addr = 8'hB2; sfr_wdata = 8'h01; byte_done = 1;
    @(negedge clk);
    sfr_wr = 0; byte_done = 0;
    check("R9 byte_done wins over write", prog_sel, 0);

    // R10 secure set-only; R11 control layout
    sfr_write(8'hB2, 8'h40);
    check("R10 secure set", secure, 1);
    sfr_write(8'hB2, 8'hBC);
    check("R10 write 0 ignored", secure, 1);
    preboot_in = 1;
    sfr_read(8'hB2, r); check("R11 ctrl layout", r, 8'hC0);
    preboot_in = 0;
    sfr_read(8'hB2, r); check("R11 preboot follows input", r, 8'h40);
    @(negedge clk); sfr_rd = 0; sfr_addr = 8'hB2;
    #1 check("R11 rdata gated by sfr_rd", sfr_rdata, 0);
    sfr_read(8'h33, r); check("R11 unknown address", r, 8'h00);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    check("R10 reset clears secure", secure, 0);

    repeat (3) @(negedge clk);
    check("R2 all expected requests seen", q.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule